// File: doc/BRIEF.md
# Serial Register Write Port

This block is the target side of a three-wire serial control link: an active-low select, a bit clock and a data line, all driven by a host. The host lowers the select and shifts in a header byte (a 7-bit device identity followed by a direction bit), then a register pointer byte, then one or more data bytes. Each complete data byte lands in a 16-entry by 8-bit register file. The pointer then advances, so one selected window can fill several consecutive registers. The port only accepts writes. A header that names another device, or that asks for a read, makes the port ignore the rest of the window.

The three serial lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and rising bit-clock edges are found in the system clock domain. For this to work, the system clock must run at least four times faster than the bit clock. The register file contents are presented continuously on a flat parallel bus. Register k occupies bits [8k+7:8k].

Top module: `spi_wr_regport`

## Requirements
- R1: After synchronous reset, every register of the file reads 0x00 on `regs_out`.
- R2: Data is sampled on rising `sclk_in` edges while `cs_n_in` is low, MSB first. A window is accepted when its first eight bits equal 0x30, which is identity 0011000 followed by direction bit 0. The next eight bits form the pointer, and the following eight bits are written to register[pointer].
- R3: If the identity differs from 0011000, no register changes for the rest of that window.
- R4: If the direction bit (8th bit) is 1, no register changes for the rest of that window.
- R5: Every further complete data byte in the same window goes to the register one above the previous one (pointer + 1, 8-bit wrap).
- R6: A data byte that is cut short by `cs_n_in` rising before its eighth bit changes no register. Bytes completed earlier in the window stay written.
- R7: A data byte aimed at a pointer value of 16 or more is dropped. In a burst that crosses from 15 to 16, only the bytes below 16 are stored.
- R8: A bit-clock rising edge that completes a data byte arrives between system clock edges. The register shows the new value after the fourth system clock rising edge that follows it, and not earlier.
- R9: Raising `cs_n_in` discards any partial header, pointer or data bits. The next window starts again at bit 0 of the header.
- R10: Bit-clock edges while `cs_n_in` is high change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Active-low window select from the host |
| sclk_in | input | 1 | Serial bit clock from the host |
| sdi_in | input | 1 | Serial data from the host |
| regs_out | output | 128 | Register file contents, register k at bits [8k+7:8k] |

## Verification
Any fault in the bit counter, the header match or the pointer shows up as a wrong byte, or a byte in the wrong register, on `regs_out`. It is visible four system clocks after the bit-clock edge that finished the byte. The bench holds its own model of the register file and updates it on that exact cycle. It compares the whole bus on every clock, so an early, late, misplaced or missing write is reported in the cycle it appears. A failure to ignore a window shows as a change to a register that should have kept its value, in the same four-cycle window.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int DW = 8;
    localparam int PW = 8;

    typedef enum logic [1:0] {
        PH_HEADER,
        PH_POINTER,
        PH_DATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] cur, input logic bit_in);
        return {cur[DW-2:0], bit_in};
    endfunction

    function automatic logic [DW-1:0] header_word(input logic [DW-2:0] dev_id);
        return {dev_id, 1'b0};
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regport_pkg::*;
#(
    parameter logic [DW-2:0] DEV_ID = 7'b0011000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_s,
    input  logic    sclk_s,
    input  logic    sdi_s,
    output logic    sclk_rise,
    output logic    ignoring,
    output wr_req_t wr_req
);
    localparam int CW = $clog2(DW);
    localparam logic [DW-1:0] HDR = header_word(DEV_ID);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shreg_q;
    logic [PW-1:0] ptr_q;
    logic          sclk_prev_q;
    logic [DW-1:0] byte_nxt;
    logic          byte_done;

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign byte_nxt  = shift_in(shreg_q, sdi_s);
    assign byte_done = (cnt_q == CW'(DW - 1));
    assign ignoring  = (phase_q == PH_IGNORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_HEADER;
            cnt_q       <= '0;
            shreg_q     <= '0;
            ptr_q       <= '0;
            sclk_prev_q <= 1'b0;
            wr_req      <= '0;
        end else begin
            sclk_prev_q <= sclk_s;
            wr_req.en   <= 1'b0;
            if (cs_n_s) begin
                phase_q <= PH_HEADER;
                cnt_q   <= '0;
            end else if (sclk_rise) begin
                shreg_q <= byte_nxt;
                cnt_q   <= cnt_q + 1'b1;
                if (byte_done) begin
                    unique case (phase_q)
                        PH_HEADER:  phase_q <= (byte_nxt == HDR) ? PH_POINTER : PH_IGNORE;
                        PH_POINTER: begin
                            ptr_q   <= byte_nxt;
                            phase_q <= PH_DATA;
                        end
                        PH_DATA: begin
                            wr_req.en   <= 1'b1;
                            wr_req.addr <= ptr_q;
                            wr_req.data <= byte_nxt;
                            ptr_q       <= ptr_q + 1'b1;
                        end
                        PH_IGNORE:  phase_q <= PH_IGNORE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr_req,
    output logic [NREG*DW-1:0] regs
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DW-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (wr_req.en && (wr_req.addr == PW'(r)))
                val_q <= wr_req.data;
        end
        assign regs[r*DW +: DW] = val_q;
    end
endmodule

// File: rtl/spi_wr_regport.sv
module spi_wr_regport
    import spi_regport_pkg::*;
#(
    parameter int            NREG   = 16,
    parameter int            SYNC   = 2,
    parameter logic [DW-2:0] DEV_ID = 7'b0011000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_in,
    input  logic               sclk_in,
    input  logic               sdi_in,
    output logic [NREG*DW-1:0] regs_out
);
    logic [2:0]    raw_in;
    logic [2:0]    sync_out;
    logic          cs_q;
    logic          sclk_q;
    logic          sdi_q;
    logic          rise;
    logic          skipping;
    wr_req_t       wr_req;
    logic          wr_en;
    logic [PW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    assign raw_in = {cs_n_in, sclk_in, sdi_in};

    spi_in_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_in),
        .dout(sync_out)
    );

    assign {cs_q, sclk_q, sdi_q} = sync_out;

    spi_frame_fsm #(.DEV_ID(DEV_ID)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_q),
        .sclk_s   (sclk_q),
        .sdi_s    (sdi_q),
        .sclk_rise(rise),
        .ignoring (skipping),
        .wr_req   (wr_req)
    );

    assign wr_en   = wr_req.en;
    assign wr_addr = wr_req.addr;
    assign wr_data = wr_req.data;

    spi_reg_bank #(.NREG(NREG)) i_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_req(wr_req),
        .regs  (regs_out)
    );
endmodule

// File: rtl/spi_wr_regport_chk.sv
module spi_wr_regport_chk #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int PW   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_sync,
    input logic               rise,
    input logic               skipping,
    input logic               wr_en,
    input logic [PW-1:0]      wr_addr,
    input logic [DW-1:0]      wr_data,
    input logic [NREG*DW-1:0] regs
);
    logic          last_ok_q;
    logic [PW-1:0] last_addr_q;
    logic [DW-1:0] last_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ok_q   <= 1'b0;
            last_addr_q <= '0;
            last_data_q <= '0;
        end else begin
            last_ok_q   <= wr_en && (int'(wr_addr) < NREG);
            last_addr_q <= wr_addr;
            last_data_q <= wr_data;
        end
    end

    // R2: an in-range write request appears in the file on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        last_ok_q |-> (regs[int'(last_addr_q)*DW +: DW] == last_data_q));

    // R2: a write request only follows a detected bit-clock rise
    p_write_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rise));

    // R3 / R4: a rejected window issues no write
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (rst)
        skipping |=> !wr_en);

    // R7: an out-of-range pointer leaves the file untouched
    p_drop_high_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_addr) >= NREG)) |=> $stable(regs));

    // R8: each completed byte yields exactly one single-cycle request
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R10: no request while the select is inactive
    p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        cs_sync |=> !wr_en);
endmodule

bind spi_wr_regport spi_wr_regport_chk #(.NREG(NREG), .DW(8), .PW(8)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_sync (cs_q),
    .rise    (rise),
    .skipping(skipping),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs    (regs_out)
);

// File: tb/test_spi_wr_regport.sv
module test_spi_wr_regport;
    localparam int NREG = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b0;
    logic              sdi = 1'b0;
    logic [NREG*8-1:0] regs_out;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    typedef struct {
        int       due;
        int       idx;
        bit [7:0] val;
    } pend_t;

    pend_t    pend_q[$];
    bit [7:0] mdl [NREG];
    bit [7:0] payload[$];

    spi_wr_regport i_spi_wr_regport (
        .clk     (clk),
        .rst     (rst),
        .cs_n_in (cs_n),
        .sclk_in (sclk),
        .sdi_in  (sdi),
        .regs_out(regs_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit [7:0] rd(input int i);
        return regs_out[i*8 +: 8];
    endfunction

    // per-clock comparison against the reference model (R8 timing included)
    always @(negedge clk) begin
        if (cmp_on) begin
            while (pend_q.size() > 0 && pend_q[0].due <= cyc) begin
                mdl[pend_q[0].idx] = pend_q[0].val;
                void'(pend_q.pop_front());
            end
            for (int i = 0; i < NREG; i++) begin
                n_cmp++;
                if (rd(i) !== mdl[i]) begin
                    n_bad++;
                    $display("FAIL %s/R8 cycle %0d reg%0d actual %02h expected %02h",
                             cur_req, cyc, i, rd(i), mdl[i]);
                end
            end
        end
    end

    task automatic check_reg(input int i, input bit [7:0] exp, input string req);
        n_cmp++;
        if (rd(i) !== exp) begin
            n_bad++;
            $display("FAIL %s reg%0d actual %02h expected %02h", req, i, rd(i), exp);
        end
    endtask

    // one bit: low half with data set, then rising edge; returns the rise cycle
    task automatic bit_out(input bit b, output int rise_cyc);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        rise_cyc = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic byte_out(input bit [7:0] v, input int nbits, input bit store, input int idx);
        int rc;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            sclk = 1'b0;
            sdi  = v[7-k];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            rc = cyc;
            if (store && k == 7 && idx < NREG) pend_q.push_back('{rc + 4, idx, v});
            repeat (4) @(negedge clk);
        end
    endtask

    // full window: header, pointer, payload bytes, then cut_bits of a partial byte
    task automatic frame(input bit [6:0] id, input bit rw, input bit [7:0] ptr, input int cut_bits);
        bit ok;
        bit [7:0] p;
        ok = (id == 7'b0011000) && !rw;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        byte_out({id, rw}, 8, 1'b0, 0);
        byte_out(ptr, 8, 1'b0, 0);
        p = ptr;
        foreach (payload[j]) begin
            byte_out(payload[j], 8, ok, int'(p));
            p = p + 8'd1;
        end
        if (cut_bits > 0) byte_out(8'hC3, cut_bits, 1'b0, 0);
        @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int rc;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset contents
        for (int i = 0; i < NREG; i++) check_reg(i, 8'h00, "R1");
        cmp_on = 1'b1;

        // R2: single write
        cur_req = "R2";
        payload = '{8'hA5};
        frame(7'b0011000, 1'b0, 8'd3, 0);
        check_reg(3, 8'hA5, "R2");

        // R5: burst with pointer increment
        cur_req = "R5";
        payload = '{8'h11, 8'h22, 8'h33, 8'h44};
        frame(7'b0011000, 1'b0, 8'd5, 0);
        check_reg(5, 8'h11, "R5");
        check_reg(8, 8'h44, "R5");

        // R3: wrong identity
        cur_req = "R3";
        payload = '{8'hFF, 8'hEE};
        frame(7'b0011001, 1'b0, 8'd3, 0);
        check_reg(3, 8'hA5, "R3");
        check_reg(4, 8'h00, "R3");

        // R4: read request ignored
        cur_req = "R4";
        payload = '{8'h99};
        frame(7'b0011000, 1'b1, 8'd5, 0);
        check_reg(5, 8'h11, "R4");

        // R6: truncated second byte
        cur_req = "R6";
        payload = '{8'h5A};
        frame(7'b0011000, 1'b0, 8'd0, 5);
        check_reg(0, 8'h5A, "R6");
        check_reg(1, 8'h00, "R6");

        // R7: burst across the top, then a far pointer
        cur_req = "R7";
        payload = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
        frame(7'b0011000, 1'b0, 8'd14, 0);
        check_reg(14, 8'hE1, "R7");
        check_reg(15, 8'hE2, "R7");
        check_reg(0, 8'h5A, "R7");
        payload = '{8'h77};
        frame(7'b0011000, 1'b0, 8'h20, 0);
        check_reg(0, 8'h5A, "R7");

        // R10: a full valid bit pattern clocked with select high
        cur_req = "R10";
        for (int k = 7; k >= 0; k--) bit_out(rc == -1 ? 1'b0 : 8'h30 >> k & 1, rc);
        for (int k = 7; k >= 0; k--) bit_out((8'h02 >> k) & 1, rc);
        for (int k = 7; k >= 0; k--) bit_out((8'hBD >> k) & 1, rc);
        @(negedge clk);
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        check_reg(2, 8'h00, "R10");

        // R9: partial header abandoned, then a clean window
        cur_req = "R9";
        payload = '{};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        byte_out(8'h30, 5, 1'b0, 0);
        @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        payload = '{8'h6C};
        frame(7'b0011000, 1'b0, 8'd9, 0);
        check_reg(9, 8'h6C, "R9");

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule